// File: doc/BRIEF.md
# Four-Register 8-bit Multicycle Processor Core

This core is a small 8-bit processor that runs from a conventional microprocessor system bus. It has a 16-bit address, separate 8-bit data input and output, read and write strobes, separate memory and I/O request strobes, and a direction line for an external bus transceiver. It holds four 8-bit general registers A, B, C and D. A and B can be used together as a 16-bit pair with A as the high byte, and so can C and D with C as the high byte. It also has a 16-bit program counter, a 16-bit stack pointer and three flags: carry, zero and minus.

Instructions are one to four bytes long. The opcode comes first. Operand bytes carry register fields, an immediate value, a port number, or a 16-bit address stored low byte first. A sequencer fetches one byte per cycle and then spends one internal cycle executing the instruction. Instructions that touch memory, ports or the stack then add one or two bus cycles. The present sequencer state is brought out so that a debug display can follow it.

Top module: `quad8_core`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the state output is 0 (fetch) and the bus reads memory at address 0000h. The program counter, stack pointer, the four registers and the flags all start at zero, so a PUSH issued first writes to FFFFh.
- R2: An instruction's bytes are read one per cycle from consecutive addresses. The length is 1 byte for 00h, 10h, 18h and 19h. It is 3 bytes for 0Ah, 0Fh, 11h–17h, 1Ah, 1Bh and 1Ch. It is 4 bytes for 0Bh and 0Ch, and 2 bytes for every other opcode up to 22h. After the last byte comes one cycle in state 1 with no request strobe, then the instruction's bus cycles in state 2, and the next fetch starts right after them.
- R3: Registers are encoded A=00, B=01, C=10, D=11. Two-register instructions give the destination in bits [3:2] of byte 2 and the source in bits [1:0]. Single-register instructions give the register in bits [1:0].
- R4: ADD (01h), ADC (02h), SUB (03h) and SBB (04h) write the 8-bit result to the destination. ADC adds the carry and SBB subtracts it. C takes bit 8 of the 9-bit sum or difference, Z is set when the result is zero, and M takes result bit 7.
- R5: AND (05h), OR (06h), XOR (07h), NOT (08h, one register), INC (1Dh) and DEC (1Eh) update Z and M from their result. They leave C unchanged.
- R6: MOV r,r (09h), MOV r,imm (0Ah, value in byte 3), MOV r,[addr] (0Bh) and MOV [addr],r (0Ch) move data. Bytes 3 and 4 hold the address low byte first. None of these changes a flag.
- R7: Pair-indirect MOV r,[pair] (1Fh) and MOV [pair],r (20h) take the register from bits [2:1] and the pair from bit 0, where 0 selects AB and 1 selects CD. INC pair (21h) and DEC pair (22h) use bit 0 and carry or borrow across the whole 16 bits without touching the flags.
- R8: MOV SP,addr (1Ch) loads SP. PUSH (0Dh) first decrements SP and then writes the register to [SP]. POP (0Eh) first reads [SP] into the register and then increments SP.
- R9: CALL (0Fh) writes the return address to the stack, high byte first at SP−1 and then low byte at SP−2, and jumps. RET (10h) reads the low byte and then the high byte, raising SP after each read.
- R10: JP (11h) always jumps. JPC, JPNC, JPM, JPNM, JPZ and JPNZ (12h–17h) jump when C is set or clear, M is set or clear, or Z is set or clear. SCF (18h) sets C and CCF (19h) clears it.
- R11: IN (1Ah) and OUT (1Bh) use the I/O request strobe. The address is 00h followed by the port number taken from byte 3.
- R12: Each bus transfer lasts exactly one cycle. Read and write are never active together, and each one comes with exactly one of the memory or I/O requests. The direction output is 0 in write cycles and 1 in all other cycles.
- R13: NOP (00h) and any opcode above 22h take one byte and change nothing except the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | output | 16 | Bus address |
| din | input | 8 | Read data, captured at the end of a read cycle |
| dout | output | 8 | Write data |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| mreq | output | 1 | Memory request |
| iorq | output | 1 | I/O request |
| dir | output | 1 | 0 while the core drives the data bus |
| state | output | 2 | Sequencer state: 0 fetch, 1 execute, 2 bus |

## Verification
The core has no parameters, so the bench builds it exactly as it is. The bench pairs it with a 4 KiB memory that repeats across the address space, which lets the reset-time stack write at FFFFh and ordinary data at 0800h share one small array. Ports return their own number XORed with A5h. The test program drives every opcode, wraps results at 00h and FFh, and carries pair values across a byte. It includes nested calls and both outcomes of every conditional jump, so every flag rule shows up in which port writes occur.

// File: rtl/quad8_core.sv
module quad8_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        rd,
  output logic        wr,
  output logic        mreq,
  output logic        iorq,
  output logic        dir,
  output logic [1:0]  state
);
  localparam logic [1:0] ST_FETCH = 2'd0, ST_EXEC = 2'd1, ST_BUS = 2'd2;

  logic [1:0]  st, idx;
  logic        step;
  logic [7:0]  r  [4];
  logic [7:0]  ir [4];
  logic [15:0] pc, sp;
  logic        cf, zf, mf;

  function automatic logic [2:0] ilen(input logic [7:0] o);
    case (o)
      8'h00, 8'h10, 8'h18, 8'h19: return 3'd1;
      8'h0A, 8'h0F, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17,
      8'h1A, 8'h1B, 8'h1C: return 3'd3;
      8'h0B, 8'h0C: return 3'd4;
      default: return (o <= 8'h22) ? 3'd2 : 3'd1;
    endcase
  endfunction

  wire [7:0]  op    = ir[0];
  wire [7:0]  fop   = (idx == 2'd0) ? din : ir[0];
  wire [1:0]  rdst  = ir[1][3:2];
  wire [1:0]  rsrc  = ir[1][1:0];
  wire [1:0]  rpr   = ir[1][2:1];
  wire        psel  = ir[1][0];
  wire [7:0]  va    = r[rdst];
  wire [7:0]  vb    = r[rsrc];
  wire [15:0] pv    = psel ? {r[2], r[3]} : {r[0], r[1]};
  wire [15:0] tgt   = {ir[2], ir[1]};
  wire [15:0] abs16 = {ir[3], ir[2]};
  wire [15:0] pnx   = (op == 8'h21) ? pv + 16'd1 : pv - 16'd1;

  logic [7:0] alu_y;
  logic       alu_c;

  always_comb begin
    alu_y = va;
    alu_c = cf;
    case (op)
      8'h01: {alu_c, alu_y} = {1'b0, va} + {1'b0, vb};
      8'h02: {alu_c, alu_y} = {1'b0, va} + {1'b0, vb} + {8'd0, cf};
      8'h03: {alu_c, alu_y} = {1'b0, va} - {1'b0, vb};
      8'h04: {alu_c, alu_y} = {1'b0, va} - {1'b0, vb} - {8'd0, cf};
      8'h05: alu_y = va & vb;
      8'h06: alu_y = va | vb;
      8'h07: alu_y = va ^ vb;
      8'h08: alu_y = ~vb;
      8'h1D: alu_y = vb + 8'd1;
      8'h1E: alu_y = vb - 8'd1;
      default: ;
    endcase
  end

  always_comb begin
    addr = pc; dout = 8'h00;
    rd = 1'b0; wr = 1'b0; mreq = 1'b0; iorq = 1'b0;
    if (st == ST_FETCH) begin
      mreq = 1'b1; rd = 1'b1;
    end else if (st == ST_BUS) begin
      case (op)
        8'h0B: begin addr = abs16; mreq = 1'b1; rd = 1'b1; end
        8'h0C: begin addr = abs16; mreq = 1'b1; wr = 1'b1; dout = vb; end
        8'h0D: begin addr = sp; mreq = 1'b1; wr = 1'b1; dout = vb; end
        8'h0E, 8'h10: begin addr = sp; mreq = 1'b1; rd = 1'b1; end
        8'h0F: begin addr = sp; mreq = 1'b1; wr = 1'b1; dout = step ? pc[7:0] : pc[15:8]; end
        8'h1A: begin addr = {8'h00, ir[2]}; iorq = 1'b1; rd = 1'b1; end
        8'h1B: begin addr = {8'h00, ir[2]}; iorq = 1'b1; wr = 1'b1; dout = vb; end
        8'h1F: begin addr = pv; mreq = 1'b1; rd = 1'b1; end
        8'h20: begin addr = pv; mreq = 1'b1; wr = 1'b1; dout = r[rpr]; end
        default: ;
      endcase
    end
  end

  assign dir   = ~wr;
  assign state = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_FETCH; idx <= 2'd0; step <= 1'b0;
      pc <= 16'h0000; sp <= 16'h0000;
      cf <= 1'b0; zf <= 1'b0; mf <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        r[i]  <= 8'h00;
        ir[i] <= 8'h00;
      end
    end else begin
      case (st)
        ST_FETCH: begin
          ir[idx] <= din;
          pc <= pc + 16'd1;
          if ({1'b0, idx} + 3'd1 == ilen(fop)) begin
            idx <= 2'd0;
            st  <= ST_EXEC;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        ST_EXEC: begin
          st <= ST_FETCH;
          step <= 1'b0;
          case (op)
            8'h01, 8'h02, 8'h03, 8'h04: begin
              r[rdst] <= alu_y; cf <= alu_c; zf <= (alu_y == 8'h00); mf <= alu_y[7];
            end
            8'h05, 8'h06, 8'h07: begin
              r[rdst] <= alu_y; zf <= (alu_y == 8'h00); mf <= alu_y[7];
            end
            8'h08, 8'h1D, 8'h1E: begin
              r[rsrc] <= alu_y; zf <= (alu_y == 8'h00); mf <= alu_y[7];
            end
            8'h09: r[rdst] <= vb;
            8'h0A: r[rsrc] <= ir[2];
            8'h0B, 8'h0C, 8'h0E, 8'h10, 8'h1A, 8'h1B, 8'h1F, 8'h20: st <= ST_BUS;
            8'h0D, 8'h0F: begin sp <= sp - 16'd1; st <= ST_BUS; end
            8'h11: pc <= tgt;
            8'h12: if (cf)  pc <= tgt;
            8'h13: if (!cf) pc <= tgt;
            8'h14: if (mf)  pc <= tgt;
            8'h15: if (!mf) pc <= tgt;
            8'h16: if (zf)  pc <= tgt;
            8'h17: if (!zf) pc <= tgt;
            8'h18: cf <= 1'b1;
            8'h19: cf <= 1'b0;
            8'h1C: sp <= tgt;
            8'h21, 8'h22: begin
              if (psel) begin r[2] <= pnx[15:8]; r[3] <= pnx[7:0]; end
              else      begin r[0] <= pnx[15:8]; r[1] <= pnx[7:0]; end
            end
            default: ;
          endcase
        end
        default: begin
          st <= ST_FETCH;
          case (op)
            8'h0B, 8'h1A: r[rsrc] <= din;
            8'h0E: begin r[rsrc] <= din; sp <= sp + 16'd1; end
            8'h1F: r[rpr] <= din;
            8'h0F: begin
              if (!step) begin sp <= sp - 16'd1; step <= 1'b1; st <= ST_BUS; end
              else pc <= tgt;
            end
            8'h10: begin
              sp <= sp + 16'd1;
              if (!step) begin pc[7:0] <= din; step <= 1'b1; st <= ST_BUS; end
              else pc[15:8] <= din;
            end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/quad8_core_props.sv
module quad8_core_props (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rd,
  input logic        wr,
  input logic        mreq,
  input logic        iorq,
  input logic        dir,
  input logic [1:0]  state
);
  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (addr == 16'h0000 && mreq && rd && state == 2'd0));

  assert_exec_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> !(mreq || iorq));

  assert_exec_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |=> (state != 2'd1));

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

  assert_fetch_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) ##1 (state == 2'd0) |-> (addr == $past(addr) + 16'd1));

  assert_fetch_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> (mreq && rd && !wr && !iorq && dir));

  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) |-> ((mreq != iorq) && !(rd && wr)));

  assert_no_idle_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq || iorq) |-> (rd || wr));
endmodule

bind quad8_core quad8_core_props i_props (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
  .mreq(mreq), .iorq(iorq), .dir(dir), .state(state)
);

// File: tb/test_quad8_core.sv
module test_quad8_core;
  localparam int PERIOD = 10;
  localparam int MAXC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr;
  logic [7:0]  din, dout;
  logic        rd, wr, mreq, iorq, dir;
  logic [1:0]  state;

  quad8_core i_quad8_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .rd(rd), .wr(wr), .mreq(mreq), .iorq(iorq), .dir(dir), .state(state)
  );

  always #(PERIOD/2) clk = ~clk;

  logic [7:0] mem  [4096];
  logic [7:0] rmem [4096];
  string      tagmem [int];
  assign din = iorq ? (addr[7:0] ^ 8'hA5) : mem[addr[11:0]];

  typedef struct {
    bit          io;
    logic [15:0] a;
    logic [7:0]  d;
    int          cyc;
    string       tg;
  } wr_t;
  wr_t exq[$];

  int checks = 0, errors = 0, halt_cyc = -1, pa = 0;
  logic [15:0] halt_pc;
  string tg = "R2";
  bit done = 1'b0;

  task automatic check(input bit ok, input string t, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", t, msg);
    end
  endtask

  task automatic e(input logic [7:0] b);
    mem[pa[11:0]] = b; tagmem[pa] = tg; pa++;
  endtask
  task automatic mvi(input logic [1:0] rg, input logic [7:0] v); e(8'h0A); e({6'd0, rg}); e(v); endtask
  task automatic op2(input logic [7:0] o, input logic [1:0] d, input logic [1:0] s); e(o); e({4'd0, d, s}); endtask
  task automatic op1(input logic [7:0] o, input logic [1:0] rg); e(o); e({6'd0, rg}); endtask
  task automatic outp(input logic [1:0] rg, input logic [7:0] p); e(8'h1B); e({6'd0, rg}); e(p); endtask
  task automatic b3(input logic [7:0] o, input logic [15:0] w); e(o); e(w[7:0]); e(w[15:8]); endtask
  task automatic probe();
    for (int k = 0; k < 6; k++) begin
      logic [15:0] j;
      mvi(2'd2, 8'h12 + 8'(k));
      j = 16'(pa + 6);
      b3(8'h12 + 8'(k), j);
      outp(2'd2, 8'h10);
    end
  endtask
  task automatic dump(input logic [1:0] rg); outp(rg, 8'h11); probe(); endtask

  task automatic build();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h810] = 8'h3C;
    tg = "R1"; op1(8'h0D, 2'd0);
    tg = "R8"; b3(8'h1C, 16'h0F00);
    tg = "R4";
    mvi(0, 8'h7F); mvi(1, 8'h01); op2(8'h01, 0, 1); dump(0);
    mvi(0, 8'hFF); op2(8'h01, 0, 1); dump(0);
    op2(8'h02, 0, 1); dump(0);
    mvi(0, 8'h01); mvi(1, 8'h02); op2(8'h03, 0, 1); dump(0);
    mvi(0, 8'h05); mvi(1, 8'h03); op2(8'h04, 0, 1); dump(0);
    tg = "R5";
    e(8'h18); mvi(0, 8'hF0); mvi(1, 8'h0F); op2(8'h05, 0, 1); dump(0);
    e(8'h19); op2(8'h06, 0, 1); dump(0);
    e(8'h18); mvi(3, 8'h55); op2(8'h07, 3, 3); dump(3);
    op1(8'h08, 1); dump(1);
    e(8'h19); mvi(3, 8'hFF); op1(8'h1D, 3); dump(3);
    op1(8'h1E, 3); dump(3);
    tg = "R3"; op2(8'h09, 0, 1); op2(8'h09, 3, 0); outp(3, 8'h11); outp(0, 8'h11);
    tg = "R6";
    e(8'h0C); e(8'h03); e(8'h00); e(8'h08);
    e(8'h0B); e(8'h01); e(8'h10); e(8'h08); outp(1, 8'h11);
    e(8'h0B); e(8'h00); e(8'h00); e(8'h08); outp(0, 8'h11); dump(0);
    tg = "R7";
    mvi(2, 8'h08); mvi(3, 8'h0F); op1(8'h21, 1); e(8'h1F); e(8'h01); outp(0, 8'h11);
    mvi(3, 8'hFF); op1(8'h21, 1); outp(2, 8'h11); outp(3, 8'h11);
    mvi(0, 8'h01); mvi(1, 8'h00); op1(8'h22, 0); outp(0, 8'h11); outp(1, 8'h11);
    e(8'h20); e(8'h03); e(8'h0B); e(8'h01); e(8'h00); e(8'h09); outp(1, 8'h11);
    e(8'h1F); e(8'h04); outp(2, 8'h11);
    tg = "R8";
    mvi(0, 8'h11); op1(8'h0D, 0); mvi(1, 8'h22); op1(8'h0D, 1);
    op1(8'h0E, 3); op1(8'h0E, 2); outp(2, 8'h11); outp(3, 8'h11);
    tg = "R9"; mvi(0, 8'h40); b3(8'h0F, 16'h0C00); outp(0, 8'h11);
    tg = "R11"; e(8'h1A); e(8'h00); e(8'h37); outp(0, 8'h11);
    tg = "R13"; e(8'h18); e(8'h00); e(8'h40); e(8'hFF); outp(0, 8'h11); dump(0);
    tg = "R10"; e(8'h19); b3(8'h11, 16'(pa + 6)); outp(0, 8'h12); dump(0);
    tg = "R2"; b3(8'h11, 16'(pa));
    pa = 32'h0C00; tg = "R9";
    outp(0, 8'h12); op1(8'h1D, 0); mvi(1, 8'h77); b3(8'h0F, 16'h0C80); e(8'h10);
    pa = 32'h0C80; outp(1, 8'h13); e(8'h10);
  endtask

  function automatic int mlen(input logic [7:0] o);
    if (o == 8'h00 || o == 8'h10 || o == 8'h18 || o == 8'h19 || o > 8'h22) return 1;
    if (o == 8'h0B || o == 8'h0C) return 4;
    if (o == 8'h0A || o == 8'h0F || o == 8'h1A || o == 8'h1B || o == 8'h1C ||
        (o >= 8'h11 && o <= 8'h17)) return 3;
    return 2;
  endfunction

  task automatic put(input bit io, input logic [15:0] a, input logic [7:0] d, input int c, input string t);
    wr_t x;
    x.io = io; x.a = a; x.d = d; x.cyc = c; x.tg = t;
    exq.push_back(x);
    if (!io) rmem[a[11:0]] = d;
  endtask

  task automatic model();
    logic [7:0] g [4];
    logic [15:0] pc, sp, pv, tgt, a16, start;
    logic c, z, m, take;
    logic [7:0] op, b1, b2, b3v, y;
    logic [8:0] w;
    int t, nb;
    string ttag;
    for (int i = 0; i < 4096; i++) rmem[i] = mem[i];
    for (int i = 0; i < 4; i++) g[i] = 8'h00;
    pc = 16'h0; sp = 16'h0; c = 0; z = 0; m = 0; t = 0;
    for (int n = 0; n < 5000; n++) begin
      start = pc;
      op = rmem[pc[11:0]]; b1 = rmem[12'(pc + 1)]; b2 = rmem[12'(pc + 2)]; b3v = rmem[12'(pc + 3)];
      ttag = tagmem.exists(int'(pc)) ? tagmem[int'(pc)] : "R2";
      tgt = {b2, b1}; a16 = {b3v, b2};
      pv = b1[0] ? {g[2], g[3]} : {g[0], g[1]};
      if (op == 8'h11 && tgt == start) begin
        halt_cyc = t; halt_pc = start; break;
      end
      pc = pc + 16'(mlen(op));
      t = t + mlen(op);
      nb = 0; take = 0;
      case (op)
        8'h01, 8'h02, 8'h03, 8'h04: begin
          if (op == 8'h01) w = {1'b0, g[b1[3:2]]} + {1'b0, g[b1[1:0]]};
          else if (op == 8'h02) w = {1'b0, g[b1[3:2]]} + {1'b0, g[b1[1:0]]} + 9'(c);
          else if (op == 8'h03) w = {1'b0, g[b1[3:2]]} - {1'b0, g[b1[1:0]]};
          else w = {1'b0, g[b1[3:2]]} - {1'b0, g[b1[1:0]]} - 9'(c);
          g[b1[3:2]] = w[7:0]; c = w[8]; z = (w[7:0] == 0); m = w[7];
        end
        8'h05, 8'h06, 8'h07: begin
          if (op == 8'h05) y = g[b1[3:2]] & g[b1[1:0]];
          else if (op == 8'h06) y = g[b1[3:2]] | g[b1[1:0]];
          else y = g[b1[3:2]] ^ g[b1[1:0]];
          g[b1[3:2]] = y; z = (y == 0); m = y[7];
        end
        8'h08, 8'h1D, 8'h1E: begin
          if (op == 8'h08) y = ~g[b1[1:0]];
          else if (op == 8'h1D) y = g[b1[1:0]] + 8'd1;
          else y = g[b1[1:0]] - 8'd1;
          g[b1[1:0]] = y; z = (y == 0); m = y[7];
        end
        8'h09: g[b1[3:2]] = g[b1[1:0]];
        8'h0A: g[b1[1:0]] = b2;
        8'h0B: begin nb = 1; g[b1[1:0]] = rmem[a16[11:0]]; end
        8'h0C: begin nb = 1; put(0, a16, g[b1[1:0]], t + 1, ttag); end
        8'h0D: begin nb = 1; sp = sp - 1; put(0, sp, g[b1[1:0]], t + 1, ttag); end
        8'h0E: begin nb = 1; g[b1[1:0]] = rmem[sp[11:0]]; sp = sp + 1; end
        8'h0F: begin
          nb = 2; sp = sp - 1; put(0, sp, pc[15:8], t + 1, ttag);
          sp = sp - 1; put(0, sp, pc[7:0], t + 2, ttag); pc = tgt;
        end
        8'h10: begin
          nb = 2; pc[7:0] = rmem[sp[11:0]]; sp = sp + 1;
          pc[15:8] = rmem[sp[11:0]]; sp = sp + 1;
        end
        8'h11: take = 1;
        8'h12: take = c;
        8'h13: take = !c;
        8'h14: take = m;
        8'h15: take = !m;
        8'h16: take = z;
        8'h17: take = !z;
        8'h18: c = 1;
        8'h19: c = 0;
        8'h1A: begin nb = 1; g[b1[1:0]] = b2 ^ 8'hA5; end
        8'h1B: begin nb = 1; put(1, {8'h00, b2}, g[b1[1:0]], t + 1, ttag); end
        8'h1C: sp = tgt;
        8'h1F: begin nb = 1; g[b1[2:1]] = rmem[pv[11:0]]; end
        8'h20: begin nb = 1; put(0, pv, g[b1[2:1]], t + 1, ttag); end
        8'h21, 8'h22: begin
          pv = (op == 8'h21) ? pv + 1 : pv - 1;
          if (b1[0]) begin g[2] = pv[15:8]; g[3] = pv[7:0]; end
          else begin g[0] = pv[15:8]; g[1] = pv[7:0]; end
        end
        default: ;
      endcase
      if (take) pc = tgt;
      t = t + 1 + nb;
    end
  endtask

  initial begin
    build();
    model();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(state == 2'd0 && addr == 16'h0000 && mreq && rd && !wr, "R1",
          $sformatf("in reset state=%0d addr=%h mreq=%b rd=%b, expected 0 0000 1 1", state, addr, mreq, rd));
    rst_n = 1'b1;
    for (int k = 0; k < MAXC; k++) begin
      if (k == 0)
        check(state == 2'd0 && addr == 16'h0000 && mreq && rd, "R1",
              $sformatf("first cycle state=%0d addr=%h, expected 0 0000", state, addr));
      check(!(rd && wr) && ((rd || wr) == (mreq || iorq)) && !(mreq && iorq) && (dir == !wr), "R12",
            $sformatf("cycle %0d rd=%b wr=%b mreq=%b iorq=%b dir=%b, expected one request per transfer and dir=~wr",
                      k, rd, wr, mreq, iorq, dir));
      if (wr) begin
        if (exq.size() == 0) begin
          check(0, "R2", $sformatf("cycle %0d unexpected write %h<=%h, expected none", k, addr, dout));
        end else begin
          wr_t x;
          x = exq.pop_front();
          check(iorq == x.io && addr == x.a && dout == x.d && k == x.cyc, x.tg,
                $sformatf("write io=%b addr=%h data=%h cycle=%0d, expected io=%b addr=%h data=%h cycle=%0d",
                          iorq, addr, dout, k, x.io, x.a, x.d, x.cyc));
        end
        if (mreq) mem[addr[11:0]] = dout;
      end
      if (k == halt_cyc)
        check(state == 2'd0 && addr == halt_pc && mreq && rd, "R2",
              $sformatf("halt fetch state=%0d addr=%h, expected 0 %h", state, addr, halt_pc));
      if (halt_cyc >= 0 && k == halt_cyc + 8) break;
      @(negedge clk);
    end
    check(halt_cyc >= 0 && exq.size() == 0, "R2",
          $sformatf("writes left=%0d halt=%0d, expected 0 and a halt cycle", exq.size(), halt_cyc));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2: watchdog expired, actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule